// File: doc/BRIEF.md
# Operand Forwarding Select Logic

This block decides, for each of the two ALU source operands of the instruction in the execute stage of a five-stage in-order pipeline, where that operand should come from. The choices are the value read from the register file, the result held in the execute/memory pipeline register, or the result held in the memory/writeback pipeline register. It compares the two source register numbers of the executing instruction against the destination numbers and write-enable flags of the two older instructions still in flight. For each operand it drives a 2-bit select that steers the operand multiplexer in front of the ALU.

The logic is purely combinational and has no clock or reset. The two selects are computed independently of each other. A destination of register 0 never causes forwarding, and neither does an instruction that does not write a register. When both older instructions target the same source register, the younger one wins, because it holds the newer value. A producer three or more instructions ahead is not handled here. The register file writes in the first half of the cycle and reads in the second half, so that value is already correct on the register-file path.

Top module: `fwd_unit`

## Requirements
- R1: `sel_a` is 2'b10 (take the execute/memory result) whenever `exm_wen` is 1, `exm_dst` is nonzero and `exm_dst` equals `src_a`.
- R2: `sel_b` is 2'b10 whenever `exm_wen` is 1, `exm_dst` is nonzero and `exm_dst` equals `src_b`.
- R3: A select is 2'b01 (take the memory/writeback result) when `mwb_wen` is 1, `mwb_dst` is nonzero, `mwb_dst` equals that operand's source number, and the execute/memory stage does not qualify under R1/R2 for that operand.
- R4: When both older stages qualify for the same operand, the select is 2'b10: the execute/memory stage wins.
- R5: A destination number of 0 never produces a forwarding select from that stage, even with its write enable set.
- R6: A stage whose write enable is 0 never produces a forwarding select, whatever its destination number.
- R7: When neither stage qualifies, the select is 2'b00 (register-file value). The code 2'b11 is never driven.
- R8: `sel_a` depends only on `src_a` and the stage inputs, and `sel_b` depends only on `src_b` and the stage inputs. Changing one source number leaves the other operand's select unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_a | input | REG_W (5) | First source register number of the instruction in execute |
| src_b | input | REG_W (5) | Second source register number of the instruction in execute |
| exm_dst | input | REG_W (5) | Destination register number held in the execute/memory register |
| exm_wen | input | 1 | Register-write flag of the execute/memory instruction |
| mwb_dst | input | REG_W (5) | Destination register number held in the memory/writeback register |
| mwb_wen | input | 1 | Register-write flag of the memory/writeback instruction |
| sel_a | output | 2 | Operand A source: 00 register file, 01 memory/writeback, 10 execute/memory |
| sel_b | output | 2 | Operand B source, same encoding as `sel_a` |

## Verification
The bench targets chains in which both older instructions write the same register the executing one reads. A design with the priority reversed would feed the ALU a stale value there. It drives register 0 as a destination with write enable set, which a design missing the zero check would wrongly forward. It also drives matching destinations with write enable clear, which a design ignoring the flag would forward from an instruction that never writes. Random stimulus is biased toward a handful of register numbers so matches on one operand, on both, and across both stages come up often. A bench model of the operand multiplexers shows a stale or wrong value whenever a select goes astray, or when one operand's select leaks into the other.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_MWB = 2'b01,
    FWD_EXM = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/fwd_hit.sv
// One producer-versus-source comparison: a producer qualifies only if it
// writes a register, that register is not register 0, and the numbers agree.
module fwd_hit #(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] src,
  input  logic [REG_W-1:0] dst,
  input  logic             wen,
  output logic             hit
);
  logic dst_nonzero;
  logic num_equal;

  always_comb begin
    dst_nonzero = |dst;
    num_equal   = (dst == src);
    hit         = wen & dst_nonzero & num_equal;
  end
endmodule

// File: rtl/fwd_pick.sv
// Priority choice for one operand: the younger producer wins.
module fwd_pick
  import fwd_pkg::*;
(
  input  logic     exm_hit,
  input  logic     mwb_hit,
  output fwd_sel_e sel
);
  always_comb begin
    if (exm_hit)      sel = FWD_EXM;
    else if (mwb_hit) sel = FWD_MWB;
    else              sel = FWD_RF;
  end

  always_comb begin
    // R4
    pick_prio_chk: assert (!exm_hit || sel == FWD_EXM);
    // R7
    pick_idle_chk: assert (exm_hit || mwb_hit || sel == FWD_RF);
  end
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
  import fwd_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] src_a,
  input  logic [REG_W-1:0] src_b,
  input  logic [REG_W-1:0] exm_dst,
  input  logic             exm_wen,
  input  logic [REG_W-1:0] mwb_dst,
  input  logic             mwb_wen,
  output logic [1:0]       sel_a,
  output logic [1:0]       sel_b
);
  localparam int NSRC = 2;

  logic [REG_W-1:0] src_v   [NSRC];
  logic             exm_hit [NSRC];
  logic             mwb_hit [NSRC];
  fwd_sel_e         sel_v   [NSRC];

  assign src_v[0] = src_a;
  assign src_v[1] = src_b;

  for (genvar g = 0; g < NSRC; g++) begin : g_opnd
    fwd_hit #(.REG_W(REG_W)) u_exm (
      .src(src_v[g]), .dst(exm_dst), .wen(exm_wen), .hit(exm_hit[g])
    );
    fwd_hit #(.REG_W(REG_W)) u_mwb (
      .src(src_v[g]), .dst(mwb_dst), .wen(mwb_wen), .hit(mwb_hit[g])
    );
    fwd_pick u_pick (
      .exm_hit(exm_hit[g]), .mwb_hit(mwb_hit[g]), .sel(sel_v[g])
    );
  end

  assign sel_a = sel_v[0];
  assign sel_b = sel_v[1];

  always_comb begin
    // R7
    sel_legal_chk: assert (sel_a != 2'b11 && sel_b != 2'b11);
    // R5
    zero_dst_chk: assert (!(exm_dst == '0 && mwb_dst == '0) ||
                          (sel_a == 2'b00 && sel_b == 2'b00));
    // R6
    no_wen_chk: assert (exm_wen || mwb_wen ||
                        (sel_a == 2'b00 && sel_b == 2'b00));
    // R1
    exm_match_chk: assert (sel_a != 2'b10 || (exm_dst == src_a && exm_wen));
    // R3
    mwb_match_chk: assert (sel_a != 2'b01 ||
                           (mwb_dst == src_a && mwb_wen && mwb_dst != '0));
  end
endmodule

// File: tb/sim_fwd_unit.sv
module sim_fwd_unit;
  localparam int REG_W = 5;

  logic clk;
  logic rst_n;
  logic [REG_W-1:0] src_a, src_b, exm_dst, mwb_dst;
  logic exm_wen, mwb_wen;
  logic [1:0] sel_a, sel_b;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit done  = 0;

  fwd_unit #(.REG_W(REG_W)) u0 (
    .src_a(src_a), .src_b(src_b), .exm_dst(exm_dst), .exm_wen(exm_wen),
    .mwb_dst(mwb_dst), .mwb_wen(mwb_wen), .sel_a(sel_a), .sel_b(sel_b)
  );

  initial clk = 0;
  always #2.5 clk = ~clk;

  // Independent reference for one operand's select.
  function automatic logic [1:0] ref_sel(input logic [REG_W-1:0] s,
      input logic [REG_W-1:0] ed, input logic ew,
      input logic [REG_W-1:0] md, input logic mw);
    if (ew && ed != 0 && ed == s) return 2'b10;
    if (mw && md != 0 && md == s) return 2'b01;
    return 2'b00;
  endfunction

  // Model of the ALU operand multiplexer fed by the select.
  function automatic logic [31:0] opnd_mux(input logic [1:0] sel,
      input logic [31:0] rf, input logic [31:0] ex, input logic [31:0] wb);
    case (sel)
      2'b10:   return ex;
      2'b01:   return wb;
      default: return rf;
    endcase
  endfunction

  task automatic drive(input logic [REG_W-1:0] a, input logic [REG_W-1:0] b,
      input logic [REG_W-1:0] ed, input logic ew,
      input logic [REG_W-1:0] md, input logic mw);
    @(posedge clk);
    src_a <= a; src_b <= b; exm_dst <= ed; exm_wen <= ew;
    mwb_dst <= md; mwb_wen <= mw;
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [1:0] act,
      input logic [1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b (a=%0d b=%0d ed=%0d ew=%b md=%0d mw=%b)",
               req, act, exp, src_a, src_b, exm_dst, exm_wen, mwb_dst, mwb_wen);
    end
  endtask

  task automatic chk_both(input string req);
    chk(req, sel_a, ref_sel(src_a, exm_dst, exm_wen, mwb_dst, mwb_wen));
    chk(req, sel_b, ref_sel(src_b, exm_dst, exm_wen, mwb_dst, mwb_wen));
    total++;
    if (opnd_mux(sel_a, 32'h1111, 32'hEEEE, 32'hBBBB) !==
        opnd_mux(ref_sel(src_a, exm_dst, exm_wen, mwb_dst, mwb_wen),
                 32'h1111, 32'hEEEE, 32'hBBBB)) begin
      bad++;
      $display("FAIL %s: operand A value actual=%h expected=%h", req,
               opnd_mux(sel_a, 32'h1111, 32'hEEEE, 32'hBBBB),
               opnd_mux(ref_sel(src_a, exm_dst, exm_wen, mwb_dst, mwb_wen),
                        32'h1111, 32'hEEEE, 32'hBBBB));
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000 && !done) begin
        bad++; total++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    logic [1:0] keep;
    int seed_v;
    rst_n = 0;
    src_a = '0; src_b = '0; exm_dst = '0; mwb_dst = '0;
    exm_wen = 0; mwb_wen = 0;
    repeat (3) @(posedge clk);
    rst_n = 1;
    @(negedge clk);
    // R7: idle inputs give register-file selects
    chk("R7 reset", sel_a, 2'b00);
    chk("R7 reset", sel_b, 2'b00);

    // R1
    drive(5'd3, 5'd4, 5'd3, 1, 5'd9, 1);  chk("R1", sel_a, 2'b10);
    // R2
    drive(5'd3, 5'd4, 5'd4, 1, 5'd9, 1);  chk("R2", sel_b, 2'b10);
    // R3 on both operands
    drive(5'd7, 5'd8, 5'd2, 1, 5'd7, 1);  chk("R3", sel_a, 2'b01);
    drive(5'd7, 5'd8, 5'd2, 1, 5'd8, 1);  chk("R3", sel_b, 2'b01);
    // R4: both stages write the same register
    drive(5'd1, 5'd1, 5'd1, 1, 5'd1, 1);  chk("R4", sel_a, 2'b10);
    chk("R4", sel_b, 2'b10);
    // R5: register 0 destinations with write enables set
    drive(5'd0, 5'd0, 5'd0, 1, 5'd0, 1);  chk("R5", sel_a, 2'b00);
    chk("R5", sel_b, 2'b00);
    drive(5'd0, 5'd6, 5'd0, 1, 5'd0, 1);  chk("R5", sel_a, 2'b00);
    // R5: register 0 in EX/MEM must fall through to a real MEM/WB match
    drive(5'd0, 5'd6, 5'd0, 1, 5'd6, 1);  chk("R5", sel_b, 2'b01);
    // R6: matching numbers but no write
    drive(5'd5, 5'd5, 5'd5, 0, 5'd5, 0);  chk("R6", sel_a, 2'b00);
    chk("R6", sel_b, 2'b00);
    drive(5'd5, 5'd5, 5'd5, 0, 5'd5, 1);  chk("R6", sel_a, 2'b01);
    // R7: no match
    drive(5'd10, 5'd11, 5'd12, 1, 5'd13, 1); chk("R7", sel_a, 2'b00);
    chk("R7", sel_b, 2'b00);
    // R8: change src_b only, sel_a must hold
    drive(5'd9, 5'd2, 5'd9, 1, 5'd2, 1);
    keep = sel_a;
    chk("R8", sel_b, 2'b01);
    drive(5'd9, 5'd9, 5'd9, 1, 5'd2, 1);
    chk("R8", sel_a, keep);
    chk("R8", sel_b, 2'b10);

    // Random stimulus with few register numbers to force collisions.
    seed_v = $urandom(32'd20240611);
    for (int i = 0; i < 3000; i++) begin
      drive(REG_W'($urandom % 4), REG_W'($urandom % 4), REG_W'($urandom % 4),
            1'($urandom), REG_W'($urandom % 4), 1'($urandom));
      chk_both("R1 R2 R3 R4 R5 R6 R7 R8 random");
    end
    for (int i = 0; i < 500; i++) begin
      drive(REG_W'($urandom), REG_W'($urandom), REG_W'($urandom),
            1'($urandom), REG_W'($urandom), 1'($urandom));
      chk_both("R7 wide random");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule